// File: doc/BRIEF.md
# Core Power and Clock Gating Controller

This block decides when the core clock of a small processor may run. Three things can hold the core clock: an active-low stop input, a software no-clock bit, and a standby request. The stop input and the no-clock bit have the same effect. Standby is a low-power idle state that any enabled interrupt ends. The block produces a core clock enable that the clock tree uses to gate the free-running reference clock. The enable changes only while the reference clock is low, so no core clock pulse is ever shortened.

A small register write port carries three registers. The power register holds the no-clock bit and one off bit for each peripheral. The PLL register holds the PLL power enable and the clock-source select. The standby register holds the standby request. The block refuses any write to the PLL register that would power the PLL down while the PLL is, or would become, the selected clock source. It flags such a write instead of applying it.

Standby may only be entered while the core is running. Standby survives a stop and a later restart. Interrupt detection runs on the reference clock, so it keeps working while the core clock is gated. The current mode is always visible on a two-bit status output.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: `stop_ni` passes through a two-flop synchronizer. When it is driven low before rising edge n, the mode changes to STOPPED at rising edge n+2. `core_clk_en_o` then falls on the falling edge that follows rising edge n+2. It stays low until `stop_ni` is high again.
- R2: Writing address 0 with bit 15 = 1 gates the core clock exactly as a low `stop_ni` does. Writing bit 15 = 0 returns the block to RUN. All other register contents are kept across the stop, and no reset is produced.
- R3: `core_clk_en_o` changes value only while `clk_i` is low.
- R4: At address 1, bit 15 is the PLL enable and drives `pll_en_o`; bit 14 is the PLL select and drives `pll_sel_o`. A legal write updates both bits and leaves `wr_err_o` low.
- R5: A write to address 1 with bit 15 = 0 is illegal when bit 14 = 1 or `pll_sel_o` is already 1. An illegal write changes neither PLL bit, and `wr_err_o` is high for exactly the one cycle after the write.
- R6: Writing address 2 with bit 15 = 1 while the mode is RUN enters standby. `standby_o` goes to 1, `mode_o` goes to STANDBY and `core_clk_en_o` goes low, while `periph_en_o`, `pll_en_o` and `pll_sel_o` keep their values. A write to address 2 with bit 15 = 0 has no effect.
- R7: A standby request made while the mode is not RUN is ignored. This covers a stop from `stop_ni` and a stop from the no-clock bit.
- R8: While in standby, any bit set in both `irq_pend_i` and `irq_mask_i` clears standby at the next rising edge. Pending bits that are masked have no effect. This wake-up also works while the clock is stopped: the mode goes from STANDBY_STOPPED to STOPPED.
- R9: Driving `stop_ni` low during standby gives STANDBY_STOPPED. Releasing it returns the block to STANDBY, not to RUN.
- R10: `mode_o` encodes the mode as 0 = RUN, 1 = STOPPED, 2 = STANDBY and 3 = STANDBY_STOPPED. After reset the outputs are as follows: mode RUN, `core_clk_en_o` = 1, `pll_en_o` = 0, `pll_sel_o` = 0, `periph_en_o` all ones and `wr_err_o` = 0.
- R11: Bits [PERIPH_W-1:0] of address 0 are peripheral off bits, and `periph_en_o` is their bitwise inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 = power, 1 = PLL, 2 = standby) |
| wr_data_i | input | 16 | Register write data |
| stop_ni | input | 1 | Asynchronous clock stop request, active low |
| irq_pend_i | input | IRQ_W | Pending interrupt requests |
| irq_mask_i | input | IRQ_W | Interrupt enable mask |
| core_clk_en_o | output | 1 | Glitch-free core clock enable |
| standby_o | output | 1 | Standby status flag |
| mode_o | output | 2 | Current mode encoding |
| pll_en_o | output | 1 | PLL power enable |
| pll_sel_o | output | 1 | Clock source select (1 = PLL) |
| periph_en_o | output | PERIPH_W | Peripheral enables |
| wr_err_o | output | 1 | One-cycle pulse after an illegal PLL write |

## Verification
The assertions check these behaviours on every cycle:
- the clock enable agrees with the mode;
- the PLL is never selected while it is unpowered;
- an illegal PLL write is rejected and flagged;
- standby is entered only from RUN, with the peripheral and PLL outputs unchanged;
- an enabled interrupt always ends standby;
- a stop input held low for three cycles always shows as a stopped mode.

Only the bench scenarios can show four things. The first is the exact latency of the synchronizer. The second is that masked interrupts do nothing. The third is that standby comes back after a stop and restart. The fourth is that the enable never changes while the reference clock is high, which a monitor watching both clock edges shows.

// File: rtl/pcg_pkg.sv
`timescale 1ns/1ps
package pcg_pkg;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_PWR = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PLL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_SBY = 2'd2;

  localparam int unsigned NOCK_BIT   = 15;
  localparam int unsigned PLLEN_BIT  = 15;
  localparam int unsigned PLLSEL_BIT = 14;
  localparam int unsigned SBY_BIT    = 15;

  typedef enum logic [1:0] {
    MODE_RUN      = 2'b00,
    MODE_STOP     = 2'b01,
    MODE_SBY      = 2'b10,
    MODE_SBY_STOP = 2'b11
  } mode_e;
endpackage

// File: rtl/pcg_sync.sv
`timescale 1ns/1ps
module pcg_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= RST_VAL;
        else         chain_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= RST_VAL;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pcg_regs.sv
`timescale 1ns/1ps
module pcg_regs
  import pcg_pkg::*;
#(
  parameter int unsigned PERIPH_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic              nock_o,
  output logic [PERIPH_W-1:0] periph_en_o,
  output logic              pll_en_o,
  output logic              pll_sel_o,
  output logic              sby_req_o,
  output logic              wr_err_o
);
  logic                nock_q;
  logic [PERIPH_W-1:0] poff_q;
  logic                pll_en_q, pll_sel_q, err_q;
  logic                wr_pwr, wr_pll, pll_bad;
  logic                unused_bits;

  assign wr_pwr  = wr_en_i && (wr_addr_i == ADDR_PWR);
  assign wr_pll  = wr_en_i && (wr_addr_i == ADDR_PLL);
  // unpowering the PLL while it is (or would become) the clock source
  assign pll_bad = !wr_data_i[PLLEN_BIT] && (wr_data_i[PLLSEL_BIT] || pll_sel_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nock_q <= 1'b0;
      poff_q <= '0;
    end else if (wr_pwr) begin
      nock_q <= wr_data_i[NOCK_BIT];
      poff_q <= wr_data_i[PERIPH_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pll_en_q  <= 1'b0;
      pll_sel_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= wr_pll && pll_bad;
      if (wr_pll && !pll_bad) begin
        pll_en_q  <= wr_data_i[PLLEN_BIT];
        pll_sel_q <= wr_data_i[PLLSEL_BIT];
      end
    end
  end

  assign unused_bits = ^wr_data_i;
  assign sby_req_o   = wr_en_i && (wr_addr_i == ADDR_SBY) && wr_data_i[SBY_BIT];
  assign nock_o      = nock_q;
  assign periph_en_o = ~poff_q;
  assign pll_en_o    = pll_en_q;
  assign pll_sel_o   = pll_sel_q;
  assign wr_err_o    = err_q;
endmodule

// File: rtl/pcg_mode.sv
`timescale 1ns/1ps
module pcg_mode
  import pcg_pkg::*;
#(
  parameter int unsigned IRQ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nock_i,
  input  logic             stop_s_i,
  input  logic             sby_req_i,
  input  logic [IRQ_W-1:0] irq_pend_i,
  input  logic [IRQ_W-1:0] irq_mask_i,
  output logic             gated_o,
  output logic             sby_o,
  output mode_e            mode_o
);
  logic gated_q, sby_q, wake;

  // runs on the reference clock, so it keeps working while the core is gated
  assign wake = |(irq_pend_i & irq_mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gated_q <= 1'b0;
    else         gated_q <= nock_i || !stop_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  sby_q <= 1'b0;
    else if (sby_q && wake)                       sby_q <= 1'b0;
    else if (!sby_q && sby_req_i && !gated_q && !wake) sby_q <= 1'b1;
  end

  assign gated_o = gated_q;
  assign sby_o   = sby_q;
  assign mode_o  = mode_e'({sby_q, gated_q});
endmodule

// File: rtl/pcg_clk_gate.sv
`timescale 1ns/1ps
module pcg_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic en_o
);
  // updated on the falling edge: the enable is stable through every high phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= 1'b1;
    else         en_o <= !hold_i;
  end
endmodule

// File: rtl/pwr_clk_ctrl.sv
`timescale 1ns/1ps
module pwr_clk_ctrl
  import pcg_pkg::*;
#(
  parameter int unsigned IRQ_W      = 8,
  parameter int unsigned PERIPH_W   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_addr_i,
  input  logic [15:0]         wr_data_i,
  input  logic                stop_ni,
  input  logic [IRQ_W-1:0]    irq_pend_i,
  input  logic [IRQ_W-1:0]    irq_mask_i,
  output logic                core_clk_en_o,
  output logic                standby_o,
  output logic [1:0]          mode_o,
  output logic                pll_en_o,
  output logic                pll_sel_o,
  output logic [PERIPH_W-1:0] periph_en_o,
  output logic                wr_err_o
);
  logic  stop_s, nock, sby_req, gated, sby;
  mode_e mode;

  pcg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(stop_ni), .q_o(stop_s)
  );

  pcg_regs #(.PERIPH_W(PERIPH_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .nock_o(nock), .periph_en_o(periph_en_o),
    .pll_en_o(pll_en_o), .pll_sel_o(pll_sel_o),
    .sby_req_o(sby_req), .wr_err_o(wr_err_o)
  );

  pcg_mode #(.IRQ_W(IRQ_W)) u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .nock_i(nock), .stop_s_i(stop_s), .sby_req_i(sby_req),
    .irq_pend_i(irq_pend_i), .irq_mask_i(irq_mask_i),
    .gated_o(gated), .sby_o(sby), .mode_o(mode)
  );

  pcg_clk_gate u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(gated || sby), .en_o(core_clk_en_o)
  );

  assign standby_o = sby;
  assign mode_o    = mode;
endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_clk_ctrl_chk #(
  parameter int unsigned IRQ_W    = 8,
  parameter int unsigned PERIPH_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [1:0]          wr_addr_i,
  input logic [15:0]         wr_data_i,
  input logic                stop_ni,
  input logic [IRQ_W-1:0]    irq_pend_i,
  input logic [IRQ_W-1:0]    irq_mask_i,
  input logic                core_clk_en_o,
  input logic                standby_o,
  input logic [1:0]          mode_o,
  input logic                pll_en_o,
  input logic                pll_sel_o,
  input logic [PERIPH_W-1:0] periph_en_o,
  input logic                wr_err_o
);
  logic [2:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  p_en_matches_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_clk_en_o == (mode_o == 2'd0));

  p_stop_gates_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 3'd5 && !$past(stop_ni, 1) && !$past(stop_ni, 2) && !$past(stop_ni, 3))
      |-> mode_o[0]);

  p_sel_needs_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_sel_o |-> pll_en_o);

  p_illegal_pll_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == 2'd1 && !wr_data_i[15] && (wr_data_i[14] || pll_sel_o))
      |=> (wr_err_o && pll_en_o == $past(pll_en_o) && pll_sel_o == $past(pll_sel_o)));

  p_sby_keeps_outputs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(standby_o) |-> ($stable(periph_en_o) && $stable(pll_en_o) && $stable(pll_sel_o)));

  p_sby_only_from_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(standby_o) |-> ($past(mode_o) == 2'd0));

  p_irq_wakes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (standby_o && |(irq_pend_i & irq_mask_i)) |=> !standby_o);
endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk #(.IRQ_W(IRQ_W), .PERIPH_W(PERIPH_W)) u_chk (.*);

// File: tb/tb_pwr_clk_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_clk_ctrl;
  localparam int unsigned IRQ_W = 8;
  localparam int unsigned PW    = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_addr_i = '0;
  logic [15:0]   wr_data_i = '0;
  logic          stop_ni = 1'b1;
  logic [IRQ_W-1:0] irq_pend_i = '0, irq_mask_i = '0;
  logic          core_clk_en_o, standby_o, pll_en_o, pll_sel_o, wr_err_o;
  logic [1:0]    mode_o;
  logic [PW-1:0] periph_en_o;

  int n_chk = 0, n_bad = 0, n_glitch = 0, n_edges = 0;

  always #10 clk_i = ~clk_i;

  pwr_clk_ctrl #(.IRQ_W(IRQ_W), .PERIPH_W(PW)) dut (.*);

  // R3 monitor: enable may only move while the reference clock is low
  always @(core_clk_en_o) if ($time > 0) begin
    n_edges++;
    if (clk_i !== 1'b0) n_glitch++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk_i);
    #5;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, output logic err);
    @(negedge clk_i); #2;
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i); #2;
    wr_en_i = 1'b0;
    err = wr_err_o;
  endtask

  // {data, exp pll_en, exp pll_sel, exp err}
  localparam logic [18:0] PLL_VEC [8] = '{
    {16'h8000, 1'b1, 1'b0, 1'b0},
    {16'hC000, 1'b1, 1'b1, 1'b0},
    {16'h0000, 1'b1, 1'b1, 1'b1},
    {16'h4000, 1'b1, 1'b1, 1'b1},
    {16'h8000, 1'b1, 1'b0, 1'b0},
    {16'h0000, 1'b0, 1'b0, 1'b0},
    {16'h4000, 1'b0, 1'b0, 1'b1},
    {16'hC000, 1'b1, 1'b1, 1'b0}
  };

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    logic e;
    #45 rst_ni = 1'b1;
    settle(2);
    // R10 reset state
    chk("R10 mode", mode_o, 0);
    chk("R10 en", core_clk_en_o, 1);
    chk("R10 pll", {pll_en_o, pll_sel_o}, 0);
    chk("R10 periph", periph_en_o, 8'hFF);
    chk("R10 err", wr_err_o, 0);

    // R4 / R5 table
    for (int i = 0; i < 8; i++) begin
      wr(2'd1, PLL_VEC[i][18:3], e);
      chk(PLL_VEC[i][0] ? "R5 err" : "R4 err", e, PLL_VEC[i][0]);
      settle(1);
      chk(PLL_VEC[i][0] ? "R5 pll" : "R4 pll", {pll_en_o, pll_sel_o}, PLL_VEC[i][2:1]);
      chk("R5 err pulse", wr_err_o, 0);
    end

    // R11 peripheral bits
    wr(2'd0, 16'h00A5, e);
    settle(1);
    chk("R11 periph", periph_en_o, 8'h5A);

    // R2 no-clock bit
    wr(2'd0, 16'h80A5, e);
    settle(3);
    chk("R2 mode", mode_o, 1);
    chk("R2 en", core_clk_en_o, 0);
    wr(2'd0, 16'h00A5, e);
    settle(3);
    chk("R2 resume", mode_o, 0);
    chk("R2 en", core_clk_en_o, 1);
    chk("R2 state kept", {periph_en_o, pll_en_o, pll_sel_o}, {8'h5A, 2'b11});

    // R1 synchronizer latency
    @(negedge clk_i); #2 stop_ni = 1'b0;
    @(negedge clk_i); @(negedge clk_i); #5;
    chk("R1 not yet", core_clk_en_o, 1);
    @(negedge clk_i); #5;
    chk("R1 gated", core_clk_en_o, 0);
    chk("R1 mode", mode_o, 1);
    stop_ni = 1'b1;
    settle(5);
    chk("R1 released", mode_o, 0);

    // R6 standby entry
    wr(2'd2, 16'h0000, e);
    settle(2);
    chk("R6 zero write", standby_o, 0);
    wr(2'd2, 16'h8000, e);
    settle(2);
    chk("R6 standby", {standby_o, mode_o}, {1'b1, 2'd2});
    chk("R6 en", core_clk_en_o, 0);
    chk("R6 outputs kept", {periph_en_o, pll_en_o, pll_sel_o}, {8'h5A, 2'b11});

    // R8 masked then enabled interrupt
    irq_pend_i = 8'h01; irq_mask_i = 8'h02;
    settle(3);
    chk("R8 masked", mode_o, 2);
    irq_mask_i = 8'h03;
    settle(2);
    chk("R8 wake", {standby_o, mode_o}, {1'b0, 2'd0});
    irq_pend_i = '0;

    // R9 standby across stop
    wr(2'd2, 16'h8000, e);
    settle(2);
    stop_ni = 1'b0;
    settle(5);
    chk("R9 sby_stop", mode_o, 3);
    stop_ni = 1'b1;
    settle(5);
    chk("R9 back to sby", mode_o, 2);

    // R8 wake while stopped
    stop_ni = 1'b0;
    settle(5);
    irq_pend_i = 8'h80; irq_mask_i = 8'h80;
    settle(2);
    chk("R8 stopped wake", mode_o, 1);
    irq_pend_i = '0;
    stop_ni = 1'b1;
    settle(5);
    chk("R8 run", mode_o, 0);

    // R7 request ignored while stopped
    stop_ni = 1'b0;
    settle(5);
    wr(2'd2, 16'h8000, e);
    stop_ni = 1'b1;
    settle(5);
    chk("R7 pin stop", {standby_o, mode_o}, {1'b0, 2'd0});
    wr(2'd0, 16'h8000, e);
    settle(3);
    wr(2'd2, 16'h8000, e);
    wr(2'd0, 16'h0000, e);
    settle(5);
    chk("R7 nock stop", {standby_o, mode_o}, {1'b0, 2'd0});

    chk("R3 edges seen", (n_edges > 0), 1);
    chk("R3 no glitch", n_glitch, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule